// File: doc/BRIEF.md
# Program-Store Write Steering Unit

This block sits between a processor core's external-data move path and two targets: a small on-chip scratch XRAM and the byte-write port of the program store. A single mode bit, set through a one-bit control register write, decides where core write requests go. When the bit is clear, writes land in XRAM. When it is set, writes are turned into program-store byte writes. Each program-store write carries its address, its data byte and the index of the 512-byte sector that holds it.

Before a program-store write is issued, the block compares its address against the implemented program-store size, which is a parameter of 16, 32 or 64 KB. In the 64 KB build the top 1 KB is reserved. A write that falls outside the legal range is discarded and raises a sticky error flag. Any control register write clears that flag. Reads always come from XRAM, whatever the mode bit says. XRAM locations beyond its 2048 bytes read back as 0xFF and ignore writes. While the program store reports busy, the block stalls the core by holding its ready signal low.

Top module: `psw_steer_top`

## Requirements
- R1: After reset, core_ready is 1, pm_strobe is 0, pstore_err is 0 and the mode bit is clear, so writes go to XRAM.
- R2: With the mode bit clear, an accepted write (core_req=1, core_we=1, core_ready=1) to an address below 0x0800 stores the byte in XRAM. A later read of that address returns it.
- R3: With the mode bit set, an accepted write to a legal address raises pm_strobe for exactly one cycle, starting in the cycle after acceptance, with pm_addr and pm_data equal to the request. XRAM is left unchanged.
- R4: Whenever pm_strobe is 1, pm_sector equals pm_addr[15:9], which is the 512-byte sector index.
- R5: Legal program-store addresses are 0x0000 to 0xFBFF when PM_KB=64, and below PM_KB*1024 otherwise. A write in program mode to any other address produces no strobe, and pstore_err reads 1 from the next cycle.
- R6: pstore_err stays 1 through later legal writes and reads. It returns to 0 in the cycle after a control write (ctl_wr=1).
- R7: core_ready is 0 while pm_busy is 1 and during the pm_strobe cycle. A core_req raised while core_ready is 0 is ignored.
- R8: Reads (core_we=0) return XRAM contents in either mode. core_rdata is valid together with core_rvalid=1 in the cycle after acceptance.
- R9: XRAM addresses 0x0800 and above read as 0xFF. Writes to them in XRAM mode are dropped and do not alias onto XRAM.
- R10: A control write with ctl_bit=1 sets the mode bit and one with ctl_bit=0 clears it. The new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core move request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Request address |
| core_wdata | input | 8 | Write byte |
| core_ready | output | 1 | Request accepted when high |
| core_rdata | output | 8 | Read byte |
| core_rvalid | output | 1 | Read byte valid |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_bit | input | 1 | Mode bit value written |
| pstore_err | output | 1 | Sticky rejected-write flag |
| pm_busy | input | 1 | Program store busy |
| pm_strobe | output | 1 | Program-store write strobe |
| pm_addr | output | 16 | Program-store byte address |
| pm_data | output | 8 | Program-store byte |
| pm_sector | output | 7 | Sector index of pm_addr |

## Verification
Every registered result of this block is due one clock after the request that causes it: the program-store strobe with its address, data and sector, the read byte with its valid flag, the error flag, and the new mode bit. core_ready is combinational from busy and the strobe. The bench drives each request just after a falling edge, lets one rising edge accept it, and samples shortly after the following falling edge, which is exactly one register stage later. A flash model in the bench raises busy for three cycles after each strobe. Writes issued into that stall are checked by counting strobes after busy drops.

// File: rtl/psw_pkg.sv
// Shared types and helpers for the program-store write steering unit.
// Assumes a 16-bit core data address space.
package psw_pkg;

    typedef enum logic [2:0] {
        RT_IDLE  = 3'd0,  // no accepted request
        RT_XRD   = 3'd1,  // read from XRAM
        RT_XWR   = 3'd2,  // write into XRAM
        RT_PWR   = 3'd3,  // legal program-store write
        RT_PBAD  = 3'd4,  // rejected program-store write
        RT_XDROP = 3'd5   // XRAM write beyond XRAM, discarded
    } route_e;

    // Highest legal program-store byte address for a given size in KB.
    function automatic logic [16:0] pm_last_addr(input int kb);
        if (kb == 64) return 17'h0FBFF;
        return 17'(kb * 1024 - 1);
    endfunction

endpackage

// File: rtl/psw_route.sv
// Request decoder: classifies an accepted core request into a route.
// Assumes PM_KB is 16, 32 or 64 and XRAM starts at address zero.
module psw_route
    import psw_pkg::*;
#(
    parameter int PM_KB      = 64,
    parameter int XRAM_BYTES = 2048,
    parameter int AW         = 16
) (
    input  logic          accept,
    input  logic          we,
    input  logic          pm_mode,
    input  logic [AW-1:0] addr,
    output route_e        route
);
    localparam logic [AW:0] XRAM_END = (AW+1)'(XRAM_BYTES);

    logic pm_ok;
    logic xram_hit;

    // Size check: the 64 KB build carries a reserved top region.
    generate
        if (PM_KB == 64) begin : g_reserved
            localparam logic [AW:0] LAST = pm_last_addr(PM_KB);
            always_comb pm_ok = {1'b0, addr} <= LAST;
        end else begin : g_sized
            localparam logic [AW:0] SIZE = (AW+1)'(PM_KB * 1024);
            always_comb pm_ok = {1'b0, addr} < SIZE;
        end
    endgenerate

    // XRAM window check.
    always_comb xram_hit = {1'b0, addr} < XRAM_END;

    // Pick the destination for this request.
    always_comb begin
        if (!accept)       route = RT_IDLE;
        else if (!we)      route = RT_XRD;
        else if (pm_mode)  route = pm_ok ? RT_PWR : RT_PBAD;
        else               route = xram_hit ? RT_XWR : RT_XDROP;
    end
endmodule

// File: rtl/psw_ctl.sv
// Control state: the program-store mode bit and the sticky error flag.
// Assumes a control write takes priority over a same-cycle rejection.
module psw_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_bit,
    input  logic bad_wr,
    output logic pm_mode,
    output logic err
);
    // Mode bit follows control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      pm_mode <= 1'b0;
        else if (ctl_wr) pm_mode <= ctl_bit;
    end

    // Error flag sets on a rejected write, clears on any control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (ctl_wr) err <= 1'b0;
        else if (bad_wr) err <= 1'b1;
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err && !ctl_wr |=> err);
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !err);
    assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> pm_mode == $past(ctl_bit));
endmodule

// File: rtl/psw_xram.sv
// On-chip XRAM with one registered read port and a write port.
// Assumes addresses at or above DEPTH read as all ones and never write.
module psw_xram #(
    parameter int DEPTH = 2048,
    parameter int AW    = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [AW:0] END_A = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    // Window check local to the array.
    always_comb hit = {1'b0, addr} < END_A;

    // Storage update, guarded by the window check.
    always_ff @(posedge clk) begin
        if (wr_en && hit) mem[addr[IW-1:0]] <= wdata;
    end

    // Registered read with all-ones outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= hit ? mem[addr[IW-1:0]] : {DW{1'b1}};
        end
    end

    assert_oob_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !hit |=> rdata == {DW{1'b1}});
    assert_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
endmodule

// File: rtl/psw_pm_port.sv
// Program-store write issue stage: registers one byte write per request.
// Assumes issue is only raised when the store is idle.
module psw_pm_port #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SECTOR_BITS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         data,
    output logic                  strobe,
    output logic [AW-1:0]         pm_addr,
    output logic [DW-1:0]         pm_data,
    output logic [AW-SECTOR_BITS-1:0] sector
);
    // One-cycle strobe per issued write.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= issue;
    end

    // Capture address, byte and sector with the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_addr <= '0;
            pm_data <= '0;
            sector  <= '0;
        end else if (issue) begin
            pm_addr <= addr;
            pm_data <= data;
            sector  <= addr[AW-1:SECTOR_BITS];
        end
    end

    assert_sector_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> sector == pm_addr[AW-1:SECTOR_BITS]);
    assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/psw_steer_top.sv
// Steers core move writes to XRAM or the program store by mode bit.
// Assumes the program store raises busy no later than the cycle after a strobe.
module psw_steer_top
    import psw_pkg::*;
#(
    parameter int PM_KB      = 64,
    parameter int XRAM_BYTES = 2048,
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int SECTOR_BITS = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      core_req,
    input  logic                      core_we,
    input  logic [AW-1:0]             core_addr,
    input  logic [DW-1:0]             core_wdata,
    output logic                      core_ready,
    output logic [DW-1:0]             core_rdata,
    output logic                      core_rvalid,
    input  logic                      ctl_wr,
    input  logic                      ctl_bit,
    output logic                      pstore_err,
    input  logic                      pm_busy,
    output logic                      pm_strobe,
    output logic [AW-1:0]             pm_addr,
    output logic [DW-1:0]             pm_data,
    output logic [AW-SECTOR_BITS-1:0] pm_sector
);
    localparam logic [AW:0] PM_LAST = (PM_KB == 64) ? pm_last_addr(PM_KB)
                                                     : (AW+1)'(PM_KB * 1024 - 1);

    route_e route;
    logic   accept;
    logic   pm_mode;

    // Stall the core while the store is writing or a strobe is out.
    always_comb core_ready = !pm_busy && !pm_strobe;
    always_comb accept     = core_req && core_ready;

    psw_route #(.PM_KB(PM_KB), .XRAM_BYTES(XRAM_BYTES), .AW(AW)) u_route (
        .accept (accept),
        .we     (core_we),
        .pm_mode(pm_mode),
        .addr   (core_addr),
        .route  (route)
    );

    psw_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_wr (ctl_wr),
        .ctl_bit(ctl_bit),
        .bad_wr (route == RT_PBAD),
        .pm_mode(pm_mode),
        .err    (pstore_err)
    );

    psw_xram #(.DEPTH(XRAM_BYTES), .AW(AW), .DW(DW)) u_xram (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (route == RT_XWR),
        .rd_en (route == RT_XRD),
        .addr  (core_addr),
        .wdata (core_wdata),
        .rdata (core_rdata),
        .rvalid(core_rvalid)
    );

    psw_pm_port #(.AW(AW), .DW(DW), .SECTOR_BITS(SECTOR_BITS)) u_pm (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (route == RT_PWR),
        .addr   (core_addr),
        .data   (core_wdata),
        .strobe (pm_strobe),
        .pm_addr(pm_addr),
        .pm_data(pm_data),
        .sector (pm_sector)
    );

    assert_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pm_busy |-> !core_ready);
    assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_strobe |-> {1'b0, pm_addr} <= PM_LAST);
    assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pm_strobe |-> $past(pm_mode) && $past(core_we) && $past(core_req));
    assert_no_strobe_in_xram_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_mode && !$past(pm_mode) && !ctl_wr |=> !pm_strobe);
endmodule

// File: tb/psw_steer_top_tb.sv
module psw_steer_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic        core_ready, core_rvalid, pstore_err, pm_strobe;
    logic [7:0]  core_rdata, pm_data;
    logic        ctl_wr = 1'b0, ctl_bit = 1'b0;
    logic        pm_busy = 1'b0;
    logic [15:0] pm_addr;
    logic [6:0]  pm_sector;

    int n_chk = 0, n_fail = 0;
    int n_strobe = 0, busy_left = 0;
    logic [15:0] cap_addr;
    logic [7:0]  cap_data;
    logic [6:0]  cap_sector;
    bit done = 0;

    always #2.5 clk = ~clk;

    psw_steer_top u_dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
        .core_rdata(core_rdata), .core_rvalid(core_rvalid), .ctl_wr(ctl_wr),
        .ctl_bit(ctl_bit), .pstore_err(pstore_err), .pm_busy(pm_busy),
        .pm_strobe(pm_strobe), .pm_addr(pm_addr), .pm_data(pm_data),
        .pm_sector(pm_sector)
    );

    // Program-store model: three busy cycles after each strobe.
    always @(negedge clk) begin
        if (rst_n && pm_strobe) begin
            n_strobe++;
            cap_addr   = pm_addr;
            cap_data   = pm_data;
            cap_sector = pm_sector;
            pm_busy    = 1'b1;
            busy_left  = 3;
        end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) pm_busy = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic core_op(input logic we, input logic [15:0] a, input logic [7:0] d);
        while (!core_ready) begin @(negedge clk); #1; end
        core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
        @(negedge clk); #1;
        core_req = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        core_op(1'b0, a, 8'h00);
        chk({req, " rvalid"}, core_rvalid, 1);
        chk({req, " rdata"}, core_rdata, exp);
    endtask

    task automatic ctl_write(input logic b);
        ctl_wr = 1'b1; ctl_bit = b;
        @(negedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (!core_ready) begin @(negedge clk); #1; end
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1 ready", core_ready, 1);
        chk("R1 strobe", pm_strobe, 0);
        chk("R1 err", pstore_err, 0);
    endtask

    task automatic t_xram();
        int s0 = n_strobe;
        core_op(1'b1, 16'h0010, 8'hA5);
        chk("R1 xram-mode no strobe", pm_strobe, 0);
        core_op(1'b1, 16'h07FF, 8'h3C);
        read_chk("R2 0x0010", 16'h0010, 8'hA5);
        read_chk("R2 0x07FF", 16'h07FF, 8'h3C);
        chk("R2 strobe count", n_strobe, s0);
    endtask

    task automatic t_pm_write();
        int s0;
        ctl_write(1'b1);
        s0 = n_strobe;
        core_op(1'b1, 16'h1234, 8'h5A);
        #1;
        chk("R3 strobe", pm_strobe, 1);
        chk("R3 count", n_strobe, s0 + 1);
        chk("R3 addr", cap_addr, 16'h1234);
        chk("R3 data", cap_data, 8'h5A);
        chk("R4 sector", cap_sector, 7'h09);
        chk("R7 ready low in strobe", core_ready, 0);
        @(negedge clk); #1;
        chk("R3 pulse one cycle", pm_strobe, 0);
        chk("R7 ready low busy", core_ready, 0);
        // request during stall must be ignored
        core_req = 1'b1; core_we = 1'b1; core_addr = 16'h2000; core_wdata = 8'h99;
        @(negedge clk); #1;
        core_req = 1'b0;
        wait_idle();
        @(negedge clk); #1;
        chk("R7 stalled req ignored", n_strobe, s0 + 1);
        core_op(1'b1, 16'h0010, 8'h77);
        wait_idle();
        read_chk("R8 read in pm mode / R3 xram untouched", 16'h0010, 8'hA5);
    endtask

    task automatic t_limits();
        int s0 = n_strobe;
        core_op(1'b1, 16'hFBFF, 8'h11);
        #1;
        chk("R5 last legal", n_strobe, s0 + 1);
        chk("R4 sector top", cap_sector, 7'h7D);
        chk("R5 no err legal", pstore_err, 0);
        wait_idle();
        core_op(1'b1, 16'hFC00, 8'h22);
        chk("R5 reserved err", pstore_err, 1);
        core_op(1'b1, 16'hFFFF, 8'h23);
        @(negedge clk); #1;
        chk("R5 reserved no strobe", n_strobe, s0 + 1);
        core_op(1'b1, 16'h0200, 8'h44);
        chk("R6 sticky after good write", pstore_err, 1);
        wait_idle();
        read_chk("R6 read", 16'h07FF, 8'h3C);
        chk("R6 sticky after read", pstore_err, 1);
        ctl_write(1'b0);
        chk("R6 cleared", pstore_err, 0);
        s0 = n_strobe;
        core_op(1'b1, 16'h0020, 8'h66);
        read_chk("R10 back to xram", 16'h0020, 8'h66);
        chk("R10 no strobe", n_strobe, s0);
    endtask

    task automatic t_oob();
        core_op(1'b1, 16'h0000, 8'h22);
        core_op(1'b1, 16'h0800, 8'h11);
        read_chk("R9 no alias", 16'h0000, 8'h22);
        read_chk("R9 0x0800", 16'h0800, 8'hFF);
        read_chk("R9 0x9000", 16'h9000, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_xram();
        t_pm_write();
        t_limits();
        t_oob();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule